// File: doc/BRIEF.md
# Multi-Hart Machine Timer Unit

This block is a memory-mapped machine-level timer shared by a configurable number of harts. It keeps one 64-bit time counter that advances by one on each cycle with the timebase tick enable high, and that software may load. Next to the counter sits one 64-bit compare register per hart. Each hart receives a registered, level-sensitive timer interrupt that is high while its compare value is at or below the current time, using an unsigned comparison.

Software reaches the counter and the compare array through a simple synchronous bus that has a select, a write enable, a size select (32-bit or 64-bit), an address, write data and combinational read data. Both the counter and every compare register can be written whole with a 64-bit access, or one half at a time with 32-bit accesses that keep the other half. Any accepted write to the counter makes every hart compare again against the new time. Illegal accesses raise a combinational error flag and change nothing.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset the time counter reads 0, every compare register reads all ones (0xFFFF_FFFF_FFFF_FFFF), and every interrupt output is low.
- R2: The time counter increases by exactly one at each clock edge where `tick` is high and the counter is not being written, and holds its value otherwise.
- R3: At `TIME_BASE` a 64-bit write (`bus_size`=1) loads the whole counter and a 32-bit write (`bus_size`=0) replaces bits 31:0 only; at `TIME_BASE`+4 a 32-bit write replaces bits 63:32 only. For 32-bit writes the value is taken from `bus_wdata[31:0]`. A write takes priority over a tick in the same cycle.
- R4: A 64-bit access at byte offset 4 of a slot (`TIME_BASE`+4 or a compare slot + 4) is illegal: `bus_err` is high, read data is zero, and no register changes.
- R5: Hart h's compare slot lies at `CMP_BASE` + 8*h. A 64-bit write at offset 0 loads the whole value, a 32-bit write at offset 0 replaces bits 31:0 only, a 32-bit write at offset 4 replaces bits 63:32 only; the compare registers of other harts are unchanged.
- R6: `irq[h]` is high exactly when compare[h] <= time (unsigned), and it reflects a write or an increment in the cycle after the clock edge that applied it; a compare write already at or below time raises it at that edge.
- R7: After any accepted write to the counter, every hart's interrupt is recomputed against the new time at the same edge, so a backward time write can lower interrupts that were high.
- R8: Reads return, on `bus_rdata` in the same cycle, the low 32 bits for a 32-bit read at offset 0, the full 64 bits for a 64-bit read at offset 0, and the high 32 bits for a 32-bit read at offset 4, with unused upper bits zero; this applies to the counter and to every compare slot.
- R9: An access to an address outside both the compare array and the counter slot, or one with address bits 1:0 nonzero, reads as zero, raises `bus_err`, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; counter advances on edges where high |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = 32-bit access, 1 = 64-bit access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| bus_rdata | output | 64 | Combinational read data |
| bus_err | output | 1 | Combinational error flag for the current access |
| irq | output | NUM_HARTS | Per-hart level timer interrupt |

## Verification
Read data and the error flag are combinational, so the bench samples them one time unit after driving the access, before the next rising edge. Register contents and interrupt levels change at the rising edge that takes a write or a tick, so each interrupt check is made one time unit after that edge, with no extra cycle of delay, and counter values are read back after a known number of edges with `tick` high. Ticks stay low outside the tick and priority scenarios, so every expected time value is an exact figure.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

   localparam int unsigned DATA_W = 64;
   localparam int unsigned HALF_W = 32;

   localparam logic SZ_32 = 1'b0;
   localparam logic SZ_64 = 1'b1;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_TIME = 2'd1,
      TGT_CMP  = 2'd2
   } tgt_e;

   typedef struct packed {
      tgt_e tgt;
      logic hi;
      logic err;
   } dec_t;

   // merge a write into a 64-bit register: whole, upper half or lower half
   function automatic logic [DATA_W-1:0] merge_word(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] wd,
      input logic              full,
      input logic              hi);
      if (full)
         return wd;
      else if (hi)
         return {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
      else
         return {old_v[DATA_W-1:HALF_W], wd[HALF_W-1:0]};
   endfunction

   // bus view of a 64-bit register for a given access shape
   function automatic logic [DATA_W-1:0] view_word(
      input logic [DATA_W-1:0] v,
      input logic              full,
      input logic              hi);
      if (full)
         return v;
      else if (hi)
         return {{HALF_W{1'b0}}, v[DATA_W-1:HALF_W]};
      else
         return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
   endfunction

endpackage

// File: rtl/mtu_decode.sv
module mtu_decode
   import mtu_pkg::*;
#(
   parameter int unsigned          NUM_HARTS = 4,
   parameter int unsigned          ADDR_W    = 16,
   parameter int unsigned          HART_W    = 2,
   parameter logic [ADDR_W-1:0]    CMP_BASE  = '0,
   parameter logic [ADDR_W-1:0]    TIME_BASE = '1
) (
   input  logic              sel,
   input  logic              size,
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec,
   output logic [HART_W-1:0] hart
);

   localparam int unsigned SPAN = NUM_HARTS * 8;
   localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(SPAN);
   localparam logic [ADDR_W-1:0] TIME_HI = TIME_BASE + ADDR_W'(4);

   logic [ADDR_W:0] off_x;
   logic            in_cmp;
   logic            in_time;
   logic            misalign;
   logic            bad_size;

   always_comb begin
      off_x    = {1'b0, addr} - {1'b0, CMP_BASE};
      in_cmp   = !off_x[ADDR_W] && (off_x < SPAN_X);
      in_time  = (addr == TIME_BASE) || (addr == TIME_HI);
      misalign = |addr[1:0];
      bad_size = addr[2] && (size == SZ_64);
      hart     = off_x[3 +: HART_W];

      dec.hi  = addr[2];
      dec.err = sel && (misalign || bad_size || !(in_cmp || in_time));
      if (!sel || dec.err)
         dec.tgt = TGT_NONE;
      else if (in_time)
         dec.tgt = TGT_TIME;
      else
         dec.tgt = TGT_CMP;
   end

endmodule

// File: rtl/mtu_time_ctr.sv
module mtu_time_ctr
   import mtu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              wr_full,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] time_d,
   output logic [DATA_W-1:0] time_q
);

   always_comb begin
      if (wr_en)
         time_d = merge_word(time_q, wdata, wr_full, wr_hi);
      else if (tick)
         time_d = time_q + DATA_W'(1);
      else
         time_d = time_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         time_q <= '0;
      else
         time_q <= time_d;
   end

endmodule

// File: rtl/mtu_cmp_bank.sv
module mtu_cmp_bank
   import mtu_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned HART_W    = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [HART_W-1:0]                wr_hart,
   input  logic                             wr_full,
   input  logic                             wr_hi,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [DATA_W-1:0]                time_d,
   output logic [NUM_HARTS-1:0][DATA_W-1:0] cmp_q,
   output logic [NUM_HARTS-1:0]             irq
);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic [DATA_W-1:0] cmp_d;
      logic              hit;

      always_comb begin
         hit   = wr_en && (wr_hart == HART_W'(h));
         cmp_d = hit ? merge_word(cmp_q[h], wdata, wr_full, wr_hi) : cmp_q[h];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q[h] <= '1;
            irq[h]   <= 1'b0;
         end else begin
            cmp_q[h] <= cmp_d;
            irq[h]   <= (cmp_d <= time_d);
         end
      end
   end

endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
   import mtu_pkg::*;
#(
   parameter int unsigned       NUM_HARTS = 4,
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h0000,
   parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic                 bus_size,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [63:0]          bus_wdata,
   output logic [63:0]          bus_rdata,
   output logic                 bus_err,
   output logic [NUM_HARTS-1:0] irq
);

   localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam longint unsigned CMP_END = longint'(CMP_BASE) + 8 * NUM_HARTS;

   if (NUM_HARTS < 1) begin : g_bad_harts
      $error("NUM_HARTS must be at least 1");
   end
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W must be between 4 and 32");
   end
   if ((CMP_BASE % 8) != 0 || (TIME_BASE % 8) != 0) begin : g_bad_align
      $error("base addresses must be 8-byte aligned");
   end
   if (longint'(TIME_BASE) >= longint'(CMP_BASE) && longint'(TIME_BASE) < CMP_END) begin : g_overlap
      $error("counter slot overlaps compare array");
   end
   if (CMP_END > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("compare array does not fit the address space");
   end

   dec_t                          dec;
   logic [HART_W-1:0]             dec_hart;
   logic                          wr_time;
   logic                          wr_cmp;
   logic                          wr_full;
   logic [DATA_W-1:0]             time_d;
   logic [DATA_W-1:0]             time_q;
   logic [NUM_HARTS-1:0][DATA_W-1:0] cmp_q;

   mtu_decode #(
      .NUM_HARTS (NUM_HARTS),
      .ADDR_W    (ADDR_W),
      .HART_W    (HART_W),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) u_dec (
      .sel  (bus_sel),
      .size (bus_size),
      .addr (bus_addr),
      .dec  (dec),
      .hart (dec_hart)
   );

   always_comb begin
      wr_time = bus_we && (dec.tgt == TGT_TIME);
      wr_cmp  = bus_we && (dec.tgt == TGT_CMP);
      wr_full = (bus_size == SZ_64);
   end

   mtu_time_ctr u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_time),
      .wr_full (wr_full),
      .wr_hi   (dec.hi),
      .wdata   (bus_wdata),
      .time_d  (time_d),
      .time_q  (time_q)
   );

   mtu_cmp_bank #(
      .NUM_HARTS (NUM_HARTS),
      .HART_W    (HART_W)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_cmp),
      .wr_hart (dec_hart),
      .wr_full (wr_full),
      .wr_hi   (dec.hi),
      .wdata   (bus_wdata),
      .time_d  (time_d),
      .cmp_q   (cmp_q),
      .irq     (irq)
   );

   always_comb begin
      bus_err = dec.err;
      unique case (dec.tgt)
         TGT_TIME: bus_rdata = view_word(time_q, wr_full, dec.hi);
         TGT_CMP:  bus_rdata = view_word(cmp_q[dec_hart], wr_full, dec.hi);
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
   parameter int unsigned       NUM_HARTS = 4,
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             tick,
   input logic                             bus_sel,
   input logic                             bus_we,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic [63:0]                      bus_rdata,
   input logic                             bus_err,
   input logic [NUM_HARTS-1:0]             irq,
   input logic [63:0]                      time_q,
   input logic [NUM_HARTS-1:0][63:0]       cmp_q
);

   logic time_wr;
   logic bad_wr;

   always_comb begin
      time_wr = bus_sel && bus_we && !bus_err &&
                ((bus_addr == TIME_BASE) || (bus_addr == TIME_BASE + ADDR_W'(4)));
      bad_wr  = bus_sel && bus_we && bus_err;
   end

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !time_wr) |=> (time_q == $past(time_q) + 64'd1)); // R2
   AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !time_wr) |=> (time_q == $past(time_q))); // R2
   AST_BAD_WR_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> $stable(time_q)); // R4
   AST_BAD_WR_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> $stable(cmp_q)); // R9
   AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_err) |-> (bus_rdata == 64'd0)); // R9

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
      AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         irq[h] == (cmp_q[h] <= time_q)); // R6
   end

endmodule

bind hart_timer_unit mtu_checker #(
   .NUM_HARTS (NUM_HARTS),
   .ADDR_W    (ADDR_W),
   .TIME_BASE (TIME_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .irq       (irq),
   .time_q    (time_q),
   .cmp_q     (cmp_q)
);

// File: tb/hart_timer_unit_tb.sv
module hart_timer_unit_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          NH   = 4;
   localparam int          AW   = 16;
   localparam logic [15:0] CB   = 16'h0000;
   localparam logic [15:0] TB   = 16'h7FF8;
   localparam logic        S32  = 1'b0;
   localparam logic        S64  = 1'b1;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_size = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic          bus_err;
   logic [NH-1:0] irq;

   int  n_chk = 0;
   int  n_bad = 0;
   logic last_err;
   logic [63:0] rv;
   logic        re;

   always #(CLK_PERIOD/2) clk = ~clk;

   hart_timer_unit #(
      .NUM_HARTS (NH),
      .ADDR_W    (AW),
      .CMP_BASE  (CB),
      .TIME_BASE (TB)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_size  (bus_size),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic sz);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      #1 last_err = bus_err;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic sz,
                     output logic [63:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
      #1;
      d = bus_rdata; e = bus_err;
      bus_sel = 1'b0;
   endtask

   function automatic logic [AW-1:0] slot(input int h);
      return CB + AW'(8 * h);
   endfunction

   task automatic t_reset();
      rd(TB, S64, rv, re);
      check("R1 time after reset", rv, 64'd0);
      for (int h = 0; h < NH; h++) begin
         rd(slot(h), S64, rv, re);
         check("R1 compare after reset", rv, ONES);
      end
      check("R1 irq after reset", 64'(irq), 64'd0);
   endtask

   task automatic t_cmp_writes();
      wr(slot(1), 64'h0000_0001_0000_0100, S64);
      rd(slot(1), S64, rv, re);
      check("R5 full compare write", rv, 64'h0000_0001_0000_0100);
      wr(slot(1), 64'h0000_0000_AAAA_5555, S32);
      rd(slot(1), S64, rv, re);
      check("R5 low half compare write", rv, 64'h0000_0001_AAAA_5555);
      wr(slot(1) + AW'(4), 64'h0000_0000_0000_0012, S32);
      rd(slot(1), S64, rv, re);
      check("R5 high half compare write", rv, 64'h0000_0012_AAAA_5555);
      rd(slot(1), S32, rv, re);
      check("R8 compare 32-bit low read", rv, 64'h0000_0000_AAAA_5555);
      rd(slot(1) + AW'(4), S32, rv, re);
      check("R8 compare 32-bit high read", rv, 64'h0000_0000_0000_0012);
      rd(slot(0), S64, rv, re);
      check("R5 other hart 0 untouched", rv, ONES);
      rd(slot(2), S64, rv, re);
      check("R5 other hart 2 untouched", rv, ONES);
      check("R6 no irq while compare above time", 64'(irq), 64'd0);
   endtask

   task automatic t_irq_immediate();
      wr(slot(2), 64'd0, S64);
      check("R6 compare equal to time raises irq", 64'(irq), 64'b0100);
      wr(slot(2) + AW'(4), 64'd1, S32);
      check("R6 compare raised above time clears irq", 64'(irq), 64'b0000);
   endtask

   task automatic t_tick();
      wr(slot(3), 64'd20, S64);
      @(negedge clk); tick = 1'b1;
      repeat (19) @(posedge clk);
      #1;
      check("R6 irq low at time 19", 64'(irq[3]), 64'd0);
      @(negedge clk); tick = 1'b0;
      rd(TB, S64, rv, re);
      check("R2 time after 19 ticks", rv, 64'd19);
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1;
      check("R6 irq rises when time reaches compare", 64'(irq[3]), 64'd1);
      @(negedge clk); tick = 1'b0;
      repeat (3) @(posedge clk);
      rd(TB, S64, rv, re);
      check("R2 time holds without tick", rv, 64'd20);
   endtask

   task automatic t_time_writes();
      wr(TB, 64'h0000_0005_0000_0010, S64);
      rd(TB, S64, rv, re);
      check("R3 full time write", rv, 64'h0000_0005_0000_0010);
      check("R7 irq of harts 2,3 after forward time write", 64'(irq), 64'b1100);
      wr(TB, 64'h0000_0000_FFFF_FFF0, S32);
      rd(TB, S64, rv, re);
      check("R3 low half time write", rv, 64'h0000_0005_FFFF_FFF0);
      wr(TB + AW'(4), 64'd0, S32);
      rd(TB, S64, rv, re);
      check("R3 high half time write", rv, 64'h0000_0000_FFFF_FFF0);
      check("R7 hart 2 irq cleared by time high write", 64'(irq), 64'b1000);
      rd(TB, S32, rv, re);
      check("R8 time 32-bit low read", rv, 64'h0000_0000_FFFF_FFF0);
      rd(TB + AW'(4), S32, rv, re);
      check("R8 time 32-bit high read", rv, 64'd0);
      wr(TB, 64'd3, S64);
      check("R7 backward time write clears irq", 64'(irq), 64'b0000);
   endtask

   task automatic t_priority();
      @(negedge clk);
      tick = 1'b1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = TB; bus_wdata = 64'd100; bus_size = S64;
      @(negedge clk);
      tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
      rd(TB, S64, rv, re);
      check("R3 write wins over tick", rv, 64'd100);
      check("R6 irq of hart 3 at time 100", 64'(irq), 64'b1000);
   endtask

   task automatic t_illegal();
      wr(TB + AW'(4), 64'hDEAD_BEEF_DEAD_BEEF, S64);
      check("R4 error on 64-bit time high write", 64'(last_err), 64'd1);
      rd(TB, S64, rv, re);
      check("R4 time unchanged by illegal write", rv, 64'd100);
      wr(slot(1) + AW'(4), 64'h1111_2222_3333_4444, S64);
      check("R4 error on 64-bit compare high write", 64'(last_err), 64'd1);
      rd(slot(1), S64, rv, re);
      check("R4 compare unchanged by illegal write", rv, 64'h0000_0012_AAAA_5555);
      rd(TB + AW'(4), S64, rv, re);
      check("R4 64-bit high read error", 64'(re), 64'd1);
      check("R4 64-bit high read zero", rv, 64'd0);
   endtask

   task automatic t_unmapped();
      rd(16'h4000, S64, rv, re);
      check("R9 unmapped read error", 64'(re), 64'd1);
      check("R9 unmapped read zero", rv, 64'd0);
      wr(16'h4000, 64'd7, S64);
      wr(slot(0) + AW'(2), 64'd7, S32);
      check("R9 misaligned write error", 64'(last_err), 64'd1);
      rd(slot(0), S64, rv, re);
      check("R9 compare 0 untouched by bad writes", rv, ONES);
      rd(TB, S64, rv, re);
      check("R9 time untouched by bad writes", rv, 64'd100);
      rd(slot(NH), S64, rv, re);
      check("R9 slot past last hart is unmapped", 64'(re), 64'd1);
   endtask

   logic done = 1'b0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_cmp_writes();
      t_irq_immediate();
      t_tick();
      t_time_writes();
      t_priority();
      t_illegal();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule